// File: doc/BRIEF.md
# Write Merging Store Buffer

This block sits between the store port of a processor core and a 64-bit write master on the system interconnect. The core hands it byte, half-word, word and double-word stores. The buffer collects them into entries that each cover one 64-bit aligned line of memory. A later store that falls in the same line as a waiting entry is folded into that entry, so several narrow stores leave as one 64-bit write with the union of their byte strobes. Every outgoing write is 64 bits wide and aligned, and the strobes mark which bytes it carries. The interconnect never combines writes, so this buffer is the only place where merging happens.

A store that runs past the end of its 64-bit line is split into two pieces. The lower line is handled first, and the core port completes only when the upper piece has been taken. Entries are issued on the bus in the order they were allocated. Each entry is released when its write response arrives, and responses come back in issue order. The buffer stalls the core when it has no free entry and the store cannot merge.

Each store carries an ordering attribute. A buffered store may merge and may have other writes outstanding with it. An unbuffered (strongly ordered) store follows three rules:
- It waits until every earlier write has been issued and acknowledged.
- It goes out alone and is never merged with another store.
- No further store is accepted until its own response has returned.

Top module: `wmerge_store_buf`

## Requirements
- R1: While reset is held, and just after it is released, `wr_valid` and `st_ready` are low and the buffer is empty.
- R2: Store size uses the encoding 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Store data is taken from the low bytes of `st_data`. The byte at address A travels on lane A[2:0], which is `wr_data[8*A[2:0] +: 8]` with `wr_strb[A[2:0]]` set. Every write has an address whose three low bits are zero and has at least one strobe set.
- R3: A buffered store merges into an entry when three conditions hold: the entry is the youngest one for the same 64-bit line, it is not yet issued, and it is not the entry currently presented on the bus. The merged write carries the OR of the strobes. Otherwise the store takes a new entry. Merging is allowed even when all entries are in use.
- R4: Where merged stores overlap, the byte value of the later store is the one written.
- R5: A store whose bytes cross a 64-bit boundary becomes two writes, lower line first. `st_ready` is asserted only in the cycle the upper piece is taken, so such a store is accepted no earlier than its second cycle. A store that does not cross is accepted in its first cycle.
- R6: Writes leave in entry allocation order.
- R7: The buffer has 4 entries. A store that can neither merge nor allocate holds `st_ready` low until it can.
- R8: An unbuffered store is accepted only when no write is pending or outstanding. It is never merged. No later store is accepted until its write response has arrived.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_strb` hold their values.
- R10: An entry is freed by its write response, responses arrive in issue order, and issued-but-unanswered writes never exceed the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present; held with its fields until accepted |
| st_ready | output | 1 | Store fully accepted this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Store size: 0 byte, 1 half-word, 2 word, 3 double-word |
| st_data | input | 64 | Store data in the low bytes |
| st_buffered | input | 1 | 1 = buffered (may merge), 0 = strongly ordered |
| wr_valid | output | 1 | Write transaction presented |
| wr_ready | input | 1 | Interconnect accepts the write |
| wr_addr | output | ADDR_W | 64-bit aligned write address |
| wr_data | output | 64 | Write data, one byte per lane |
| wr_strb | output | 8 | Byte strobes |
| bresp_valid | input | 1 | Write response for the oldest outstanding write |

## Verification
Two functions can fall in the same cycle: a store can merge into a line while that line's entry is waiting on the bus, and a new entry can be allocated while the oldest one is being freed by its response. The first case is provoked by holding `wr_ready` low and then storing into the line that is on the bus. It is judged by two checks: the presented payload must stay unchanged, and the store must appear later as its own write. The second case is provoked by random ready and response timing under a long store stream. It is judged by comparing a byte image built from the accepted stores with one built from the issued writes.

// File: rtl/wmerge_pkg.sv
// Package: shared types for the write merging store buffer.
// Assumes a 64-bit bus with eight byte lanes.
package wmerge_pkg;
    localparam int LANES  = 8;
    localparam int BUS_W  = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } st_size_e;

    // One line-sized piece of a store: lane data plus lane strobes.
    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [LANES-1:0] strb;
    } lane_piece_t;
endpackage

// File: rtl/wmerge_shaper.sv
// Module: wmerge_shaper
// Turns a store (address, size, data) into lane form for its own line
// and for the next line, and flags stores that cross a 64-bit boundary.
// Assumes the store data sits in the low bytes of st_data.
module wmerge_shaper
    import wmerge_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [BUS_W-1:0]  data,
    output lane_piece_t       lo_piece,
    output lane_piece_t       hi_piece,
    output logic              crosses
);
    logic [3:0]         nbytes;
    logic [2*LANES-1:0] mask_w;
    logic [2*BUS_W-1:0] data_w;

    // Shift the byte mask and the data into a two-line window.
    always_comb begin
        nbytes   = 4'd1 << size;
        mask_w   = ((16'd1 << nbytes) - 16'd1) << addr[2:0];
        data_w   = {{BUS_W{1'b0}}, data} << {addr[2:0], 3'b000};
        lo_piece = '{data: data_w[BUS_W-1:0],       strb: mask_w[LANES-1:0]};
        hi_piece = '{data: data_w[2*BUS_W-1:BUS_W], strb: mask_w[2*LANES-1:LANES]};
        crosses  = |mask_w[2*LANES-1:LANES];
    end
endmodule

// File: rtl/wmerge_queue.sv
// Module: wmerge_queue
// Entry array of the store buffer: youngest-match lookup, merge or
// allocate, in-order issue pointer and in-order release on responses.
// Assumes DEPTH is a power of two (at least 2), responses arrive only
// for issued writes and in issue order.
module wmerge_queue
    import wmerge_pkg::*;
#(
    parameter int LINE_W = 29,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_take,
    input  logic              in_merge,
    input  logic              in_so,
    input  logic [LINE_W-1:0] in_line,
    input  lane_piece_t       in_piece,
    output logic              hit_ok,
    output logic              full,
    output logic              empty,
    output logic              so_busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [LINE_W-1:0] wr_line,
    output lane_piece_t       wr_piece,
    input  logic              bresp_valid
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [LINE_W-1:0] line_q [DEPTH];
    lane_piece_t       piece_q [DEPTH];
    logic [DEPTH-1:0]  valid_q, issued_q, so_q;
    logic [PTR_W-1:0]  head_q, iss_q, tail_q, idx, young;
    logic [CNT_W-1:0]  cnt_q;
    logic              found, alloc, merge, fire;

    // Find the youngest valid entry that holds the incoming line.
    always_comb begin
        found = 1'b0;
        young = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_q + PTR_W'(k);
            if (valid_q[idx] && line_q[idx] == in_line) begin
                found = 1'b1;
                young = idx;
            end
        end
    end

    // Status, bus presentation and the actions of this cycle.
    always_comb begin
        wr_valid = valid_q[iss_q] && !issued_q[iss_q];
        wr_line  = line_q[iss_q];
        wr_piece = piece_q[iss_q];
        hit_ok   = found && !issued_q[young] && !so_q[young]
                   && !(wr_valid && iss_q == young);
        full     = (cnt_q == CNT_W'(DEPTH));
        empty    = (cnt_q == '0);
        so_busy  = |(valid_q & so_q);
        fire     = wr_valid && wr_ready;
        merge    = in_take && in_merge;
        alloc    = in_take && !in_merge;
    end

    // Control state: flags, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            issued_q <= '0;
            so_q     <= '0;
            head_q   <= '0;
            iss_q    <= '0;
            tail_q   <= '0;
            cnt_q    <= '0;
        end else begin
            if (bresp_valid) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= head_q + 1'b1;
            end
            if (fire) begin
                issued_q[iss_q] <= 1'b1;
                iss_q           <= iss_q + 1'b1;
            end
            if (alloc) begin
                valid_q[tail_q]  <= 1'b1;
                issued_q[tail_q] <= 1'b0;
                so_q[tail_q]     <= in_so;
                tail_q           <= tail_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(bresp_valid);
        end
    end

    // Payload storage: new line on allocation, per-byte overwrite on merge.
    always_ff @(posedge clk) begin
        if (alloc) begin
            line_q[tail_q]  <= in_line;
            piece_q[tail_q] <= in_piece;
        end else if (merge) begin
            for (int b = 0; b < LANES; b++) begin
                if (in_piece.strb[b]) begin
                    piece_q[young].data[8*b +: 8] <= in_piece.data[8*b +: 8];
                end
            end
            piece_q[young].strb <= piece_q[young].strb | in_piece.strb;
        end
    end
endmodule

// File: rtl/wmerge_store_buf.sv
// Module: wmerge_store_buf (top)
// Store buffer that merges stores within a 64-bit line, splits
// boundary-crossing stores into two line pieces and issues aligned,
// strobed 64-bit writes in order. Unbuffered stores wait for an empty
// buffer and block later stores until answered.
// Assumes st_* fields stay stable while st_valid waits for st_ready.
module wmerge_store_buf
    import wmerge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [63:0]       st_data,
    input  logic              st_buffered,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic [7:0]        wr_strb,
    input  logic              bresp_valid
);
    localparam int LINE_W = ADDR_W - 3;

    lane_piece_t       lo_piece, hi_piece, piece, wr_piece;
    logic              crosses, upper_q;
    logic [LINE_W-1:0] line0, piece_line, wr_line;
    logic              hit_ok, full, empty, so_busy;
    logic              can_merge, room, take;

    wmerge_shaper #(.ADDR_W(ADDR_W)) u_shaper (
        .addr     (st_addr),
        .size     (st_size),
        .data     (st_data),
        .lo_piece (lo_piece),
        .hi_piece (hi_piece),
        .crosses  (crosses)
    );

    // Pick the piece for this cycle and decide whether it can be taken.
    always_comb begin
        line0      = st_addr[ADDR_W-1:3];
        piece_line = upper_q ? line0 + LINE_W'(1) : line0;
        piece      = upper_q ? hi_piece : lo_piece;
        can_merge  = st_buffered && hit_ok;
        room       = st_buffered ? (can_merge || !full) : empty;
        take       = st_valid && !so_busy && room;
        st_ready   = take && (upper_q || !crosses);
        wr_addr    = {wr_line, 3'b000};
        wr_data    = wr_piece.data;
        wr_strb    = wr_piece.strb;
    end

    // Track whether the upper piece of a crossing store is next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= 1'b0;
        end else if (take) begin
            upper_q <= !upper_q && crosses;
        end
    end

    wmerge_queue #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_take     (take),
        .in_merge    (can_merge),
        .in_so       (!st_buffered),
        .in_line     (piece_line),
        .in_piece    (piece),
        .hit_ok      (hit_ok),
        .full        (full),
        .empty       (empty),
        .so_busy     (so_busy),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_line     (wr_line),
        .wr_piece    (wr_piece),
        .bresp_valid (bresp_valid)
    );
endmodule

// File: rtl/wmerge_store_buf_chk.sv
// Module: wmerge_store_buf_chk
// Checker bound to the store buffer top; watches its ports only and
// keeps its own count of outstanding writes.
module wmerge_store_buf_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic [ADDR_W-1:0] st_addr,
    input logic [1:0]        st_size,
    input logic [63:0]       st_data,
    input logic              st_buffered,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [63:0]       wr_data,
    input logic [7:0]        wr_strb,
    input logic              bresp_valid
);
    int outs;

    // Count writes issued but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outs <= 0;
        end else begin
            outs <= outs + ((wr_valid && wr_ready) ? 1 : 0) - (bresp_valid ? 1 : 0);
        end
    end

    AST_STRB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_strb != 8'd0); // R2

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)
                                     && $stable(wr_data) && $stable(wr_strb))); // R9

    AST_SO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !st_buffered) |-> (!wr_valid && outs == 0)); // R8

    AST_OUTS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        outs <= DEPTH); // R10
endmodule

bind wmerge_store_buf wmerge_store_buf_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/wmerge_store_buf_bench.sv
// Bench for wmerge_store_buf: directed corner cases plus seeded random
// stores, checked against byte images and expectations built by functions.
module wmerge_store_buf_bench;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 4;
    localparam int MEM_N  = 80;

    logic              clk, rst_n;
    logic              st_valid, st_ready, st_buffered;
    logic [ADDR_W-1:0] st_addr;
    logic [1:0]        st_size;
    logic [63:0]       st_data;
    logic              wr_valid, wr_ready, bresp_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [63:0]       wr_data;
    logic [7:0]        wr_strb;

    wmerge_store_buf #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_wmerge_store_buf (.*);

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int outs     = 0;
    int rdy_mode = 0;   // 0 low, 1 high, 2 random
    bit resp_en  = 1'b1;
    bit resp_rnd = 1'b0;

    logic [7:0]        exp_mem [MEM_N];
    logic [7:0]        act_mem [MEM_N];
    logic [ADDR_W-1:0] t_addr [4096];
    logic [63:0]       t_data [4096];
    logic [7:0]        t_strb [4096];
    int                t_n = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [15:0] lane_mask(input int addr, input int size);
        return ((16'd1 << (1 << size)) - 16'd1) << (addr % 8);
    endfunction

    function automatic logic [63:0] strb_bits(input logic [7:0] s);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) m[8*b +: 8] = {8{s[b]}};
        return m;
    endfunction

    function automatic logic [63:0] exp_line(input int base);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[8*b +: 8] = exp_mem[base + b];
        return v;
    endfunction

    // Bus side: drive ready/response at negedge, sample just before posedge.
    initial begin
        wr_ready    = 1'b0;
        bresp_valid = 1'b0;
        forever begin
            @(negedge clk);
            wr_ready    = (rdy_mode == 1) || (rdy_mode == 2 && ($urandom % 3) != 0);
            bresp_valid = resp_en && outs > 0 && (!resp_rnd || ($urandom % 2) == 1);
            #9;
            if (rst_n && wr_valid && wr_ready) begin
                t_addr[t_n] = wr_addr;
                t_data[t_n] = wr_data;
                t_strb[t_n] = wr_strb;
                t_n++;
                check(wr_addr[2:0] == 3'd0 && wr_strb != 8'd0, "R2", "write alignment/strobe",
                      {wr_addr, 24'd0, wr_strb}, {wr_addr[ADDR_W-1:3], 3'b000, 24'd0, 8'hFF});
                for (int b = 0; b < 8; b++)
                    if (wr_strb[b] && wr_addr + b < MEM_N) act_mem[wr_addr + b] = wr_data[8*b +: 8];
                outs++;
            end
            if (bresp_valid) outs--;
        end
    end

    // Present one store from a negedge; returns at a negedge.
    task automatic do_store(input int addr, input int size, input logic [63:0] data,
                            input bit buffered, input int max_wait,
                            output bit acc, output int lat);
        st_addr = ADDR_W'(addr); st_size = 2'(size); st_data = data;
        st_buffered = buffered; st_valid = 1'b1;
        acc = 1'b0; lat = 0;
        while (!acc && lat < max_wait) begin
            #9;
            lat++;
            if (st_ready) acc = 1'b1;
            @(negedge clk);
        end
        st_valid = 1'b0;
        if (acc)
            for (int i = 0; i < (1 << size); i++) exp_mem[addr + i] = data[8*i +: 8];
    endtask

    task automatic drain();
        int quiet = 0;
        int guard = 0;
        while (quiet < 4 && guard < 3000) begin
            @(negedge clk); #9;
            guard++;
            quiet = (outs == 0 && !wr_valid) ? quiet + 1 : 0;
        end
        @(negedge clk);
        check(quiet >= 4, "R10", "drain completes", 64'(outs), 64'd0);
    endtask

    task automatic check_txn(input int i, input int addr, input logic [7:0] strb, input string req);
        check(t_addr[i] == ADDR_W'(addr), req, "write address", 64'(t_addr[i]), 64'(addr));
        check(t_strb[i] == strb, req, "write strobes", 64'(t_strb[i]), 64'(strb));
        check((t_data[i] & strb_bits(strb)) == (exp_line(addr) & strb_bits(strb)), req,
              "write data", t_data[i] & strb_bits(strb), exp_line(addr) & strb_bits(strb));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        report();
    end

    initial begin
        bit acc;
        int lat, base, dummy;
        dummy = int'($urandom(32'd7321));
        for (int i = 0; i < MEM_N; i++) begin exp_mem[i] = 8'd0; act_mem[i] = 8'd0; end
        st_valid = 0; st_addr = 0; st_size = 0; st_data = 0; st_buffered = 1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #9;
        check(!wr_valid && !st_ready, "R1", "outputs in reset", {wr_valid, st_ready}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        st_valid = 1'b0;
        #9;
        check(!wr_valid && !st_ready, "R1", "outputs after reset", {wr_valid, st_ready}, 0);
        @(negedge clk);

        // Merge while the bus is stalled (R3, R4, R6, R9).
        rdy_mode = 0; base = t_n;
        do_store(8, 0, 64'h11, 1, 10, acc, lat);
        check(acc && lat == 1, "R5", "aligned store accepted in first cycle", 64'(lat), 64'd1);
        do_store(16, 2, 64'hAABBCCDD, 1, 10, acc, lat);
        do_store(20, 1, 64'h1234, 1, 10, acc, lat);
        do_store(17, 0, 64'h77, 1, 10, acc, lat);
        do_store(9, 0, 64'h22, 1, 10, acc, lat);
        repeat (2) @(negedge clk);
        #9;
        check(wr_valid && wr_addr == 8 && wr_strb == 8'h01 && wr_data[7:0] == 8'h11, "R9",
              "stalled write unchanged", {wr_addr, 16'd0, wr_strb, wr_data[7:0]}, {32'd8, 16'd0, 8'h01, 8'h11});
        @(negedge clk);
        rdy_mode = 1;
        drain();
        check(t_n - base == 3, "R3", "merged write count", 64'(t_n - base), 64'd3);
        check_txn(base, 8, 8'h01, "R6");
        check_txn(base + 1, 16, lane_mask(16, 2)[7:0] | lane_mask(20, 1)[7:0] | lane_mask(17, 0)[7:0], "R4");
        check_txn(base + 2, 8, lane_mask(9, 0)[7:0], "R3");

        // Split of boundary-crossing stores (R5).
        rdy_mode = 0; base = t_n;
        do_store(6, 2, 64'h44332211, 1, 10, acc, lat);
        check(acc && lat == 2, "R5", "crossing word accept cycle", 64'(lat), 64'd2);
        do_store(13, 3, 64'h8877665544332211, 1, 10, acc, lat);
        check(acc && lat == 2, "R5", "crossing dword accept cycle", 64'(lat), 64'd2);
        do_store(24, 3, 64'h0123456789ABCDEF, 1, 10, acc, lat);
        check(acc && lat == 1, "R5", "aligned dword accept cycle", 64'(lat), 64'd1);
        rdy_mode = 1;
        drain();
        check(t_n - base == 4, "R5", "split write count", 64'(t_n - base), 64'd4);
        check_txn(base, 0, lane_mask(6, 2)[7:0], "R5");
        check_txn(base + 1, 8, lane_mask(6, 2)[15:8] | lane_mask(13, 3)[7:0], "R5");
        check_txn(base + 2, 16, lane_mask(13, 3)[15:8], "R5");
        check_txn(base + 3, 24, 8'hFF, "R6");

        // Full buffer stall, merge still allowed (R7).
        rdy_mode = 0; base = t_n;
        for (int i = 0; i < 4; i++) do_store(8 * i, 0, 64'(8'hA0 + i), 1, 10, acc, lat);
        do_store(32, 0, 64'h99, 1, 6, acc, lat);
        check(!acc, "R7", "store stalled when full", 64'(acc), 64'd0);
        do_store(25, 0, 64'h5A, 1, 6, acc, lat);
        check(acc, "R7", "merge accepted when full", 64'(acc), 64'd1);
        rdy_mode = 1;
        drain();
        check(t_n - base == 4, "R7", "write count after full", 64'(t_n - base), 64'd4);
        check_txn(base + 3, 24, 8'h03, "R3");

        // Unbuffered ordering (R8).
        rdy_mode = 1; resp_en = 0; base = t_n;
        do_store(0, 2, 64'hCAFEF00D, 1, 10, acc, lat);
        repeat (2) @(negedge clk);
        do_store(8, 2, 64'h12345678, 0, 6, acc, lat);
        check(!acc, "R8", "unbuffered waits for response", 64'(acc), 64'd0);
        resp_en = 1;
        do_store(8, 2, 64'h12345678, 0, 20, acc, lat);
        check(acc, "R8", "unbuffered accepted after drain", 64'(acc), 64'd1);
        resp_en = 0;
        do_store(12, 0, 64'h3C, 1, 6, acc, lat);
        check(!acc, "R8", "later store blocked", 64'(acc), 64'd0);
        resp_en = 1;
        do_store(12, 0, 64'h3C, 1, 20, acc, lat);
        check(acc, "R8", "later store after response", 64'(acc), 64'd1);
        drain();
        check(t_n - base == 3, "R8", "unbuffered not merged", 64'(t_n - base), 64'd3);
        check_txn(base + 1, 8, 8'h0F, "R8");
        check_txn(base + 2, 8, 8'h10, "R8");

        // Seeded random stream with random bus timing (R2, R4, R6, R10).
        rdy_mode = 2; resp_rnd = 1;
        for (int n = 0; n < 400; n++) begin
            do_store(int'($urandom % 64), int'($urandom % 4), {$urandom, $urandom},
                     ($urandom % 8) != 0, 400, acc, lat);
            if (!acc) check(acc, "R7", "random store never accepted", 0, 1);
            if (($urandom % 5) == 0) repeat ($urandom % 4) @(negedge clk);
        end
        rdy_mode = 1;
        drain();
        for (int l = 0; l < MEM_N / 8; l++) begin
            logic [63:0] av, ev;
            for (int b = 0; b < 8; b++) begin
                av[8*b +: 8] = act_mem[8*l + b];
                ev[8*b +: 8] = exp_mem[8*l + b];
            end
            check(av == ev, "R4", "memory image line", av, ev);
        end
        check(outs == 0, "R10", "all writes answered", 64'(outs), 64'd0);
        report();
    end
endmodule